// File: doc/BRIEF.md
# Timer Clock Prescaler with Handshaked Clear

This block turns a source clock into the count-enable for one timer. A 10-bit free-running counter advances on the chosen source clock. A 3-bit select picks what the timer sees: nothing, an enable on every cycle, or a one-cycle pulse once every 8, 32, 64, 128, 256 or 1024 source cycles. The source is either the system clock or a separate asynchronous clock. Each domain has its own enable output, and only the selected one ever pulses.

A two-bit control register, written and read in the system clock domain, steers the clear of the counter. The clear bit drops by itself once the counter has been zeroed. The hold bit keeps the clear asserted, so several timers can be set up while halted and then released together. When the asynchronous source is selected, the clear request is carried into that domain through a synchronizer. An acknowledge comes back the same way, and the clear bit stays set until that acknowledge arrives.

Top module: `tmr_prescaler`

## Requirements
- R1: After reset (rst and arst high), rd_data reads 00 and both tick_sys and tick_async are 0.
- R2: sel = 000 gives no enable at all. sel = 001 gives an enable on every source cycle that is not a clear cycle.
- R3: sel = 010, 011, 100, 101, 110 and 111 select divide ratios 8, 32, 64, 128, 256 and 1024. The enable is a one-cycle pulse, registered one cycle after the counter's low log2(ratio) bits are all ones. Pulses are therefore exactly ratio source cycles apart.
- R4: Writing 1 to wr_data bit 0 (the clear bit) zeroes the counter. In system-clock mode with ratio 8, the first enable is seen 9 cycles after the write edge.
- R5: In system-clock mode with the hold bit at 0, the clear bit reads 1 for exactly one cycle after it is written, then reads 0.
- R6: While the hold bit (wr_data bit 1) is 1, the clear bit stays 1 once set, and no enable is produced.
- R7: Writing the hold bit to 0 while it is held makes the clear bit read 0 one cycle after the hold bit reads 0, and counting resumes at once.
- R8: With src_async = 1, tick_sys stays 0 and the counter runs on aclk. The clear bit stays 1 until a request has passed through the synchronizer into the aclk domain and its acknowledge has come back, which takes at least 4 clk cycles.
- R9: A write sets the hold bit to wr_data bit 1. rd_data always returns {hold, clear}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, register domain |
| rst | input | 1 | Synchronous active-high reset, clk domain |
| aclk | input | 1 | Asynchronous source clock |
| arst | input | 1 | Synchronous active-high reset, aclk domain |
| src_async | input | 1 | 1 = run the counter on aclk |
| sel | input | 3 | Enable select, encoding as in R2/R3 |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 2 | Bit 1 hold, bit 0 clear request |
| rd_data | output | 2 | Current {hold, clear} |
| tick_sys | output | 1 | Count-enable in the clk domain |
| tick_async | output | 1 | Count-enable in the aclk domain |

## Verification
In system-clock mode every result has a fixed latency. A write changes rd_data after its own edge. A set clear bit falls one edge later. A cleared counter first matches the /8 tap 8 edges after the clear edge, and tick_sys follows one edge after the match. A behavioural model in the bench advances on each rising edge from the same inputs, and the bench compares it with the outputs on the following falling edge. The asynchronous path has no fixed latency, so the checks there are bounds: the clear bit must stay up for at least four clk cycles and fall within a window. The spacing of tick_async pulses is counted in aclk cycles.

// File: rtl/tmr_presc_pkg.sv
package tmr_presc_pkg;
  localparam int CNT_W = 10;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_STOP   = 3'd0,
    SEL_DIRECT = 3'd1,
    SEL_D8     = 3'd2,
    SEL_D32    = 3'd3,
    SEL_D64    = 3'd4,
    SEL_D128   = 3'd5,
    SEL_D256   = 3'd6,
    SEL_D1024  = 3'd7
  } sel_e;

  // number of low counter bits that must be all ones for a divided tap
  function automatic int tap_bits(logic [SEL_W-1:0] s);
    case (sel_e'(s))
      SEL_D8:    return 3;
      SEL_D32:   return 5;
      SEL_D64:   return 6;
      SEL_D128:  return 7;
      SEL_D256:  return 8;
      SEL_D1024: return 10;
      default:   return 0;
    endcase
  endfunction

  function automatic logic tap_hit(logic [CNT_W-1:0] c, logic [SEL_W-1:0] s);
    logic [CNT_W-1:0] m;
    if (sel_e'(s) == SEL_STOP)   return 1'b0;
    if (sel_e'(s) == SEL_DIRECT) return 1'b1;
    m = (CNT_W'(1) << tap_bits(s)) - CNT_W'(1);
    return (c & m) == m;
  endfunction
endpackage

// File: rtl/presc_sync.sv
module presc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/presc_core.sv
module presc_core
  import tmr_presc_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      cnt  <= cnt + CW'(1);
      tick <= tap_hit(cnt, sel);
    end
  end

  // R4: a clear leaves the counter at zero and the enable low
  p_clear_zero_r4: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0 && !tick));

  // R2: the stop selection never yields an enable
  p_stop_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_STOP) |=> !tick);

  // R3: divided taps give single-cycle pulses
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && sel >= SEL_D8 && $past(sel) >= SEL_D8) |=> !tick);
endmodule

// File: rtl/presc_ctrl.sv
module presc_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [1:0] wr_data,
  input  logic       src_async,
  input  logic       ack,
  output logic       clr_bit,
  output logic       hold_bit
);
  logic wait_low;
  logic done;
  logic hw_clear;

  // completion: immediate on the system clock, acknowledged in async mode
  assign done     = !src_async || (ack && !wait_low);
  assign hw_clear = clr_bit && !hold_bit && done;

  always_ff @(posedge clk) begin
    if (rst) begin
      clr_bit  <= 1'b0;
      hold_bit <= 1'b0;
    end else begin
      if (wr_en) hold_bit <= wr_data[1];
      if (wr_en && wr_data[0]) clr_bit <= 1'b1;
      else if (hw_clear)       clr_bit <= 1'b0;
    end
  end

  // after a completed handshake, the acknowledge must drop before it counts again
  always_ff @(posedge clk) begin
    if (rst)                        wait_low <= 1'b0;
    else if (hw_clear && src_async) wait_low <= 1'b1;
    else if (!ack)                  wait_low <= 1'b0;
  end

  // R5: in system-clock mode an unheld clear bit lasts one cycle
  p_self_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (clr_bit && !hold_bit && !src_async && !(wr_en && wr_data[0])) |=> !clr_bit);

  // R6: hold mode keeps the clear bit
  p_hold_keeps_r6: assert property (@(posedge clk) disable iff (rst)
    (clr_bit && hold_bit) |=> clr_bit);

  // R8: without an acknowledge the async clear bit stays up
  p_wait_ack_r8: assert property (@(posedge clk) disable iff (rst)
    (clr_bit && src_async && !ack) |=> clr_bit);

  // R9: written hold value is what reads back
  p_hold_write_r9: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (hold_bit == $past(wr_data[1])));
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_presc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             aclk,
  input  logic             arst,
  input  logic             src_async,
  input  logic [SEL_W-1:0] sel,
  input  logic             wr_en,
  input  logic [1:0]       wr_data,
  output logic [1:0]       rd_data,
  output logic             tick_sys,
  output logic             tick_async
);
  localparam int XW = SEL_W + 2;

  logic             clr_bit, hold_bit, ack_s;
  logic [XW-1:0]    to_a, in_a;
  logic [SEL_W-1:0] sel_a;
  logic             async_a, req_a;

  presc_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .src_async(src_async),
    .ack      (ack_s),
    .clr_bit  (clr_bit),
    .hold_bit (hold_bit)
  );

  assign rd_data = {hold_bit, clr_bit};

  // system-clock counter, held clear while the async source is in use
  presc_core u_core_sys (
    .clk (clk),
    .rst (rst),
    .clr (clr_bit || src_async),
    .sel (sel),
    .tick(tick_sys)
  );

  // request, mode and select into the aclk domain (quasi-static except request)
  assign to_a = {sel, src_async, clr_bit};

  presc_sync #(.W(XW), .STAGES(SYNC_STAGES)) u_sync_to_a (
    .clk(aclk),
    .rst(arst),
    .d  (to_a),
    .q  (in_a)
  );

  assign {sel_a, async_a, req_a} = in_a;

  presc_core u_core_async (
    .clk (aclk),
    .rst (arst),
    .clr (req_a || !async_a),
    .sel (sel_a),
    .tick(tick_async)
  );

  // acknowledge: the request as seen in aclk, brought back to clk
  presc_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_ack (
    .clk(clk),
    .rst(rst),
    .d  (req_a),
    .q  (ack_s)
  );

  // R8: system enable is silent while the async source is selected
  p_sys_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    src_async |=> !tick_sys);
endmodule

// File: tb/tmr_prescaler_bench.sv
`timescale 1ns/1ps
module tmr_prescaler_bench;
  logic       clk = 0, aclk = 0;
  logic       rst = 1, arst = 1;
  logic       src_async = 0;
  logic [2:0] sel = 3'd0;
  logic       wr_en = 0;
  logic [1:0] wr_data = 2'b00;
  logic [1:0] rd_data;
  logic       tick_sys, tick_async;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0, rd_chk = 0, tk_chk = 0;

  // reference model state
  int m_cnt = 0;
  bit m_tick = 0, m_psr = 0, m_tsm = 0;

  always #5 clk = ~clk;
  always #18.5 aclk = ~aclk;

  tmr_prescaler u_tmr_prescaler (
    .clk(clk), .rst(rst), .aclk(aclk), .arst(arst), .src_async(src_async),
    .sel(sel), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .tick_sys(tick_sys), .tick_async(tick_async)
  );

  function automatic int ratio(logic [2:0] s);
    case (s)
      3'd2: return 8;    3'd3: return 32;   3'd4: return 64;
      3'd5: return 128;  3'd6: return 256;  3'd7: return 1024;
      default: return 1;
    endcase
  endfunction

  function automatic bit want_tick(int c, logic [2:0] s);
    if (s == 3'd0) return 0;
    if (s == 3'd1) return 1;
    return (c % ratio(s)) == ratio(s) - 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act %0d exp %0d at %0t", req, act, exp, $time);
    end
  endtask

  // model advances on each rising edge from the pre-edge values
  always @(posedge clk) begin
    bit clr, nt, np, ns;
    int nc;
    if (rst) begin
      m_cnt = 0; m_tick = 0; m_psr = 0; m_tsm = 0;
    end else begin
      clr = m_psr || src_async;
      nt  = !clr && want_tick(m_cnt, sel);
      nc  = clr ? 0 : (m_cnt + 1) % 1024;
      np  = m_psr;
      if (wr_en && wr_data[0]) np = 1;
      else if (!m_tsm)         np = 0;
      if (src_async) np = 0;
      ns  = wr_en ? wr_data[1] : m_tsm;
      m_tick = nt; m_cnt = nc; m_psr = np; m_tsm = ns;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (tk_chk) chk(tick_sys == m_tick, (sel < 2) ? "R2 tick_sys" : "R3 tick_sys",
                    tick_sys, m_tick);
    if (rd_chk) chk(rd_data == {m_tsm, m_psr}, "R9 rd_data", rd_data, {m_tsm, m_psr});
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog act %0d exp %0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic reg_wr(input logic [1:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0; wr_data = 2'b00;
  endtask

  task automatic sys_gap(output int gap);
    int n = 0;
    gap = -1;
    while (!tick_sys && n < 3000) begin @(negedge clk); n++; end
    if (!tick_sys) return;
    gap = 0;
    do begin @(negedge clk); gap++; end while (!tick_sys && gap < 3000);
  endtask

  task automatic async_gap(output int gap);
    int n = 0;
    gap = -1;
    @(negedge aclk);
    while (!tick_async && n < 3000) begin @(negedge aclk); n++; end
    if (!tick_async) return;
    gap = 0;
    do begin @(negedge aclk); gap++; end while (!tick_async && gap < 3000);
  endtask

  initial begin
    int n, g;
    repeat (4) @(negedge aclk);
    @(negedge clk); rst = 0; arst = 0;
    @(negedge clk);
    chk(rd_data == 2'b00, "R1 rd_data", rd_data, 0);
    chk(tick_sys == 0, "R1 tick_sys", tick_sys, 0);
    chk(tick_async == 0, "R1 tick_async", tick_async, 0);
    rd_chk = 1; tk_chk = 1;

    // R2: stop and undivided
    n = 0;
    repeat (20) begin @(negedge clk); n += tick_sys; end
    chk(n == 0, "R2 stop count", n, 0);
    sel = 3'd1; @(negedge clk);
    n = 0;
    repeat (20) begin @(negedge clk); n += tick_sys; end
    chk(n == 20, "R2 direct count", n, 20);

    // R3: every divided tap
    for (int s = 2; s < 8; s++) begin
      sel = 3'(s);
      repeat (3) @(negedge clk);
      sys_gap(g);
      chk(g == ratio(3'(s)), "R3 gap", g, ratio(3'(s)));
    end

    // R4: clear then first /8 pulse
    sel = 3'd2; repeat (5) @(negedge clk);
    reg_wr(2'b01);
    n = 0;
    do begin @(negedge clk); n++; end while (!tick_sys && n < 40);
    chk(n == 9, "R4 first pulse", n, 9);

    // R5: one-cycle clear bit
    reg_wr(2'b01);
    chk(rd_data[0] == 1, "R5 set", rd_data[0], 1);
    @(negedge clk);
    chk(rd_data[0] == 0, "R5 self clear", rd_data[0], 0);

    // R9: hold bit alone
    reg_wr(2'b10);
    chk(rd_data == 2'b10, "R9 hold only", rd_data, 2);
    reg_wr(2'b00);
    chk(rd_data == 2'b00, "R9 hold off", rd_data, 0);

    // R6/R7: hold and release
    sel = 3'd1;
    reg_wr(2'b11);
    n = 0;
    repeat (12) begin @(negedge clk); n += tick_sys; end
    chk(n == 0, "R6 no ticks", n, 0);
    chk(rd_data == 2'b11, "R6 kept", rd_data, 3);
    reg_wr(2'b00);
    chk(rd_data == 2'b01, "R7 hold low", rd_data, 1);
    @(negedge clk);
    chk(rd_data == 2'b00, "R7 clear drops", rd_data, 0);
    @(negedge clk);
    chk(tick_sys == 1, "R7 resumes", tick_sys, 1);

    // R8: asynchronous source
    rd_chk = 0;
    sel = 3'd2; src_async = 1;
    repeat (30) @(negedge clk);
    reg_wr(2'b01);
    chk(rd_data[0] == 1, "R8 set", rd_data[0], 1);
    n = 0;
    while (rd_data[0] && n < 60) begin @(negedge clk); n++; end
    chk(n >= 4 && n < 60, "R8 handshake len", n, 4);
    async_gap(g);
    chk(g == 8, "R8 async gap", g, 8);

    reg_wr(2'b11);
    repeat (20) @(negedge clk);
    n = 0;
    repeat (30) begin @(negedge aclk); n += tick_async; end
    chk(n == 0, "R6 async hold", n, 0);
    chk(rd_data == 2'b11, "R6 async kept", rd_data, 3);
    reg_wr(2'b00);
    n = 0;
    while (rd_data != 2'b00 && n < 60) begin @(negedge clk); n++; end
    chk(rd_data == 2'b00, "R7 async release", rd_data, 0);
    async_gap(g);
    chk(g == 8, "R7 async resumes", g, 8);

    // back to system clock
    src_async = 0;
    repeat (10) @(negedge clk);
    chk(tick_async == 0, "R8 async quiet", tick_async, 0);
    rd_chk = 1;
    sys_gap(g);
    chk(g == 8, "R3 gap after async", g, 8);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule